// File: doc/BRIEF.md
# Bus-Mastering Memory Test Sequencer with Fault Stall

This block runs a short memory test on a shared on-chip bus. A host loads a small program through the block's register port. Each program slot holds an opcode, a bus address and a data word. The host then starts the engine. While running, the engine arbitrates for the bus with a request/grant pair and writes patterns into the memory under test. It also reads words back and compares each one against the expected value stored in the slot. A read returns its data one cycle after its address phase. A single compare stage therefore holds the address and expected word while the next access issues, so reads can go out back to back.

On the first mismatch the engine stops sequencing and drops its bus request for good. It then acts only as a register slave. The host reads the failing address, the data seen and the data expected through that same port. A hardware loop unit repeats part of the program without any loop instruction in the program. The host sets a repeat count, a first slot and a last slot. Each time a bus access completes at the last slot while repeats remain, the program counter goes straight back to the first slot. A terminating slot with no fault raises a done flag and returns the engine to idle.

Top module: `memtest_seq`

## Requirements
- R1: After reset the engine is idle and does not request the bus. The status register at slave address 1 reads 0. Its bit 0 is busy, bit 1 is done and bit 2 is fail.
- R2: While running, a slot with opcode 1 (write) or 2 (read-compare) raises the bus request and drives that slot's address, with the write strobe high only for opcode 1. These outputs are held unchanged until a grant. The program counter moves on only when a grant is given.
- R3: A read-compare slot compares the word returned in the cycle after its address phase with the slot's data word. Matching reads do not stop the engine. With a permanent grant, successive accesses issue in consecutive cycles.
- R4: On the first mismatch the engine records the failing bus address (slave address 2), the returned word (address 3) and the expected word (address 4). It sets status bit 2.
- R5: From the cycle after a mismatch the bus request stays low. A compare whose access issued in the mismatch cycle is discarded, and the recorded values are not overwritten. Fail holds until the host starts the engine again.
- R6: A slot with opcode 0 (or the unused code 3), reached with no fault, sets status bit 1, clears busy and leaves the bus request low.
- R7: The repeat count (slave address 5), first slot (address 6) and last slot (address 7) are read at start. A completed access at the last slot with N repeats left returns the program counter to the first slot, with no idle cycle, and leaves N-1. A count of N runs the loop body N+1 times.
- R8: A repeat count of zero runs the loop body exactly once.
- R9: Slave writes to program slots (addresses 16 to 31, slot = address - 16) and to the loop registers are ignored while the engine is busy. Writing 1 to bit 0 of address 0 starts the engine only when it is not busy.
- R10: A new start after a fault or a completion clears done, fail and the recorded failure values, and runs the program from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sWe | input | 1 | Slave write strobe |
| sAddr | input | 5 | Slave register address |
| sWdata | input | 26 | Slave write data; a program slot is {op[1:0], addr[7:0], data[15:0]} |
| sRdata | output | 26 | Slave read data for sAddr, combinational |
| mReq | output | 1 | Bus request |
| mGnt | input | 1 | Bus grant; address phase completes when mReq and mGnt are both high |
| mWe | output | 1 | Bus write strobe |
| mAddr | output | 8 | Bus address |
| mWdata | output | 16 | Bus write data |
| mRdata | input | 16 | Bus read data, valid the cycle after a read address phase |

## Verification
The program is run under three grant patterns: a permanent grant, a grant in one cycle of three, and no grant at all. The permanent grant shows that accesses and loop returns cost no extra cycles. The sparse grant separates a design that moves on at grant from one that moves on at request. The withheld grant holds the engine busy so that blocked register writes can be read back. A failing program places a second mismatching read straight after the first. This tells apart a design that discards in-flight compares from one that overwrites the recorded failure, and a later write slot shows whether the bus request was really withdrawn.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    OP_END   = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE,
    ST_FAULT
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;    // start accepted: wipe recorded failure
    logic issueRd;  // read address phase completes this cycle
    logic capture;  // record the mismatch seen this cycle
    logic busy;     // engine running; locks configuration
  } strobes_t;

  localparam int REG_CTRL   = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_FADDR  = 2;
  localparam int REG_GOT    = 3;
  localparam int REG_EXP    = 4;
  localparam int REG_LCNT   = 5;
  localparam int REG_LSTART = 6;
  localparam int REG_LEND   = 7;

endpackage

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
  import memtest_pkg::*;
#(
  parameter int PC_W  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  opcode_e          entryOp,
  input  logic             mGnt,
  input  logic             mismatch,
  input  logic             hostStart,
  input  logic [CNT_W-1:0] loopCount,
  input  logic [PC_W-1:0]  loopStart,
  input  logic [PC_W-1:0]  loopEnd,
  output logic             mReq,
  output strobes_t         strobes,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] loopLeft,
  output logic             done,
  output logic             fail
);

  state_e state;
  logic   running, busOp, issue, loopBack;

  assign running  = (state == ST_RUN);
  assign busOp    = (entryOp == OP_WRITE) || (entryOp == OP_READ);
  assign mReq     = running && busOp;
  assign issue    = mReq && mGnt;
  assign loopBack = (pc == loopEnd) && (loopLeft != '0);

  assign done = (state == ST_DONE);
  assign fail = (state == ST_FAULT);

  always_comb begin
    strobes.clear   = hostStart && !running;
    strobes.issueRd = issue && (entryOp == OP_READ);
    strobes.capture = running && mismatch;
    strobes.busy    = running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pc       <= '0;
      loopLeft <= '0;
    end else if (!running) begin
      if (hostStart) begin
        state    <= ST_RUN;
        pc       <= '0;
        loopLeft <= loopCount;
      end
    end else begin
      if (mismatch)    state <= ST_FAULT;
      else if (!busOp) state <= ST_DONE;
      if (issue) begin
        if (loopBack) begin
          pc       <= loopStart;
          loopLeft <= loopLeft - 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/memtest_dp.sv
module memtest_dp
  import memtest_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MADDR_W = 8,
  parameter int PC_W    = 4,
  parameter int CNT_W   = 8,
  localparam int REG_W  = DATA_W + MADDR_W + 2,
  localparam int SA_W   = PC_W + 1,
  localparam int DEPTH  = 1 << PC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sWe,
  input  logic [SA_W-1:0]    sAddr,
  input  logic [REG_W-1:0]   sWdata,
  output logic [REG_W-1:0]   sRdata,
  output logic               mWe,
  output logic [MADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0]  mWdata,
  input  logic [DATA_W-1:0]  mRdata,
  input  strobes_t           strobes,
  input  logic [PC_W-1:0]    pc,
  input  logic               done,
  input  logic               fail,
  output opcode_e            entryOp,
  output logic               mismatch,
  output logic               hostStart,
  output logic [CNT_W-1:0]   loopCount,
  output logic [PC_W-1:0]    loopStart,
  output logic [PC_W-1:0]    loopEnd
);

  logic [REG_W-1:0]   prog [DEPTH];
  logic [REG_W-1:0]   cur;
  logic               regSel, progWr;
  logic [PC_W-1:0]    idx;
  logic               cmpValid;
  logic [MADDR_W-1:0] cmpAddr, failAddr;
  logic [DATA_W-1:0]  cmpExp, gotData, expData;

  assign regSel    = !sAddr[PC_W];
  assign idx       = sAddr[PC_W-1:0];
  assign progWr    = sWe && !regSel && !strobes.busy;
  assign hostStart = sWe && regSel && (idx == PC_W'(REG_CTRL)) && sWdata[0];

  // current slot drives the master port
  assign cur     = prog[pc];
  assign entryOp = opcode_e'(cur[REG_W-1 -: 2]);
  assign mAddr   = cur[DATA_W +: MADDR_W];
  assign mWdata  = cur[DATA_W-1:0];
  assign mWe     = (entryOp == OP_WRITE);

  // compare stage: one cycle behind the address phase
  assign mismatch = cmpValid && (mRdata != cmpExp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) prog[i] <= '0;
    end else if (progWr) begin
      prog[idx] <= sWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopCount <= '0;
      loopStart <= '0;
      loopEnd   <= '0;
    end else if (sWe && regSel && !strobes.busy) begin
      case (int'(idx))
        REG_LCNT:   loopCount <= sWdata[CNT_W-1:0];
        REG_LSTART: loopStart <= sWdata[PC_W-1:0];
        REG_LEND:   loopEnd   <= sWdata[PC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpAddr  <= '0;
      cmpExp   <= '0;
    end else begin
      cmpValid <= strobes.issueRd;
      cmpAddr  <= mAddr;
      cmpExp   <= mWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      failAddr <= '0;
      gotData  <= '0;
      expData  <= '0;
    end else if (strobes.capture) begin
      failAddr <= cmpAddr;
      gotData  <= mRdata;
      expData  <= cmpExp;
    end
  end

  always_comb begin
    sRdata = '0;
    if (!regSel) begin
      sRdata = prog[idx];
    end else begin
      case (int'(idx))
        REG_STATUS: sRdata = REG_W'({fail, done, strobes.busy});
        REG_FADDR:  sRdata = REG_W'(failAddr);
        REG_GOT:    sRdata = REG_W'(gotData);
        REG_EXP:    sRdata = REG_W'(expData);
        REG_LCNT:   sRdata = REG_W'(loopCount);
        REG_LSTART: sRdata = REG_W'(loopStart);
        REG_LEND:   sRdata = REG_W'(loopEnd);
        default:    sRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MADDR_W = 8,
  parameter int PC_W    = 4,
  parameter int CNT_W   = 8,
  localparam int REG_W  = DATA_W + MADDR_W + 2,
  localparam int SA_W   = PC_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sWe,
  input  logic [SA_W-1:0]    sAddr,
  input  logic [REG_W-1:0]   sWdata,
  output logic [REG_W-1:0]   sRdata,
  output logic               mReq,
  input  logic               mGnt,
  output logic               mWe,
  output logic [MADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0]  mWdata,
  input  logic [DATA_W-1:0]  mRdata
);

  strobes_t         stb;
  opcode_e          entryOp;
  logic             mismatch, hostStart, doneW, failW;
  logic [PC_W-1:0]  pcW, loopStartW, loopEndW;
  logic [CNT_W-1:0] loopCountW, loopLeftW;

  memtest_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .entryOp(entryOp), .mGnt(mGnt),
    .mismatch(mismatch), .hostStart(hostStart), .loopCount(loopCountW),
    .loopStart(loopStartW), .loopEnd(loopEndW), .mReq(mReq),
    .strobes(stb), .pc(pcW), .loopLeft(loopLeftW), .done(doneW), .fail(failW)
  );

  memtest_dp #(.DATA_W(DATA_W), .MADDR_W(MADDR_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sWe(sWe), .sAddr(sAddr), .sWdata(sWdata),
    .sRdata(sRdata), .mWe(mWe), .mAddr(mAddr), .mWdata(mWdata), .mRdata(mRdata),
    .strobes(stb), .pc(pcW), .done(doneW), .fail(failW), .entryOp(entryOp),
    .mismatch(mismatch), .hostStart(hostStart), .loopCount(loopCountW),
    .loopStart(loopStartW), .loopEnd(loopEndW)
  );

endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
  parameter int MADDR_W = 8,
  parameter int PC_W    = 4,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               sWe,
  input logic               mReq,
  input logic               mGnt,
  input logic               mWe,
  input logic [MADDR_W-1:0] mAddr,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [PC_W-1:0]    pc,
  input logic [PC_W-1:0]    loopStart,
  input logic [PC_W-1:0]    loopEnd,
  input logic [CNT_W-1:0]   loopLeft
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    mReq && !mGnt |=> (mReq && $stable(mAddr) && $stable(mWe)) || fail); // R2
  AST_FAULT_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> $past(busy)); // R4
  AST_NO_REQ_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> !mReq); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fail && !sWe |=> fail); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mReq); // R6
  AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)); // R6
  AST_LOOP_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    busy && mReq && mGnt && (pc == loopEnd) && (loopLeft != '0)
      |=> pc == $past(loopStart)); // R7

endmodule

bind memtest_seq memtest_seq_chk #(.MADDR_W(MADDR_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sWe(sWe), .mReq(mReq), .mGnt(mGnt), .mWe(mWe),
  .mAddr(mAddr), .busy(stb.busy), .done(doneW), .fail(failW), .pc(pcW),
  .loopStart(loopStartW), .loopEnd(loopEndW), .loopLeft(loopLeftW)
);

// File: tb/sim_memtest_seq.sv
module sim_memtest_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sWe = 1'b0;
  logic [4:0]  sAddr = '0;
  logic [25:0] sWdata = '0;
  logic [25:0] sRdata;
  logic        mReq, mGnt, mWe;
  logic [7:0]  mAddr;
  logic [15:0] mWdata, mRdata;

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int gntMode = 0;   // 0 always, 1 one cycle in three, 2 never
  logic gntEn = 1'b1;
  logic [15:0] mem [256];
  logic [15:0] rdReg = '0;

  int          txN = 0;
  logic [7:0]  txAddr [64];
  logic        txWe [64];
  int          txCyc [64];

  always #2 clk = ~clk;

  memtest_seq u0 (
    .clk(clk), .rstN(rstN), .sWe(sWe), .sAddr(sAddr), .sWdata(sWdata),
    .sRdata(sRdata), .mReq(mReq), .mGnt(mGnt), .mWe(mWe), .mAddr(mAddr),
    .mWdata(mWdata), .mRdata(mRdata)
  );

  assign mGnt   = mReq & gntEn;
  assign mRdata = rdReg;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    gntEn <= (gntMode == 0) ? 1'b1 : (gntMode == 1) ? ((cyc % 3) == 0) : 1'b0;
    if (mReq && mGnt) begin
      if (mWe) mem[mAddr] <= mWdata;
      else     rdReg <= mem[mAddr];
    end
  end

  always @(negedge clk) begin
    if (mReq && mGnt && txN < 64) begin
      txAddr[txN] = mAddr;
      txWe[txN]   = mWe;
      txCyc[txN]  = cyc;
      txN = txN + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] ent(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    return {op, a, d};
  endfunction

  task automatic hostWr(input logic [4:0] a, input logic [25:0] d);
    @(negedge clk);
    sWe = 1'b1; sAddr = a; sWdata = d;
    @(negedge clk);
    sWe = 1'b0;
  endtask

  task automatic hostRd(input logic [4:0] a, output logic [25:0] d);
    @(negedge clk);
    sAddr = a;
    #1 d = sRdata;
  endtask

  task automatic setLoop(input int cnt, input int st, input int en);
    hostWr(5'd5, 26'(cnt));
    hostWr(5'd6, 26'(st));
    hostWr(5'd7, 26'(en));
  endtask

  task automatic runWait(input string tag);
    logic [25:0] s;
    txN = 0;
    hostWr(5'd0, 26'd1);
    for (int k = 0; k < 2000; k++) begin
      hostRd(5'd1, s);
      if (s[0] == 1'b0) return;
    end
    check({tag, " timeout"}, 32'd1, 32'd0);
  endtask

  task automatic tReset();
    logic [25:0] s;
    hostRd(5'd1, s);
    check("R1 status", 32'(s), 32'd0);
    check("R1 mReq", 32'(mReq), 32'd0);
  endtask

  task automatic tPass();
    logic [25:0] s;
    gntMode = 0;
    setLoop(0, 0, 15);
    hostWr(5'd16, ent(2'd1, 8'h00, 16'h1111));
    hostWr(5'd17, ent(2'd1, 8'h01, 16'h2222));
    hostWr(5'd18, ent(2'd2, 8'h00, 16'h1111));
    hostWr(5'd19, ent(2'd2, 8'h01, 16'h2222));
    hostWr(5'd20, ent(2'd0, 8'h00, 16'h0));
    runWait("R3");
    hostRd(5'd1, s);
    check("R3 status done no fail", 32'(s), 32'd2);
    check("R3 access count", 32'(txN), 32'd4);
    check("R3 back-to-back", 32'(txCyc[3] - txCyc[0]), 32'd3);
    check("R2 write landed 0", 32'(mem[0]), 32'h1111);
    check("R2 write landed 1", 32'(mem[1]), 32'h2222);
    check("R6 mReq low after end", 32'(mReq), 32'd0);
  endtask

  task automatic tThrottle();
    logic [25:0] s;
    gntMode = 1;
    hostWr(5'd16, ent(2'd1, 8'h30, 16'hBEEF));
    hostWr(5'd17, ent(2'd2, 8'h30, 16'hBEEF));
    hostWr(5'd18, ent(2'd1, 8'h31, 16'h0F0F));
    hostWr(5'd19, ent(2'd2, 8'h31, 16'h0F0F));
    hostWr(5'd20, ent(2'd3, 8'h00, 16'h0));
    runWait("R2");
    hostRd(5'd1, s);
    check("R2 sparse grant done", 32'(s), 32'd2);
    check("R2 one access per grant", 32'(txN), 32'd4);
    check("R2 order addr", {txAddr[0], txAddr[1], txAddr[2], txAddr[3]}, 32'h30303131);
    check("R2 order we", {28'd0, txWe[0], txWe[1], txWe[2], txWe[3]}, 32'b1010);
    check("R2 data 0x31", 32'(mem[8'h31]), 32'h0F0F);
    gntMode = 0;
  endtask

  task automatic tFault();
    logic [25:0] s;
    hostWr(5'd16, ent(2'd1, 8'h05, 16'hAAAA));
    hostWr(5'd17, ent(2'd2, 8'h05, 16'hAAAB));
    hostWr(5'd18, ent(2'd2, 8'h05, 16'h0000));
    hostWr(5'd19, ent(2'd1, 8'h06, 16'h6666));
    hostWr(5'd20, ent(2'd0, 8'h00, 16'h0));
    runWait("R4");
    repeat (5) @(negedge clk);
    hostRd(5'd1, s);
    check("R4 status fail", 32'(s), 32'd4);
    hostRd(5'd2, s);
    check("R4 fail addr", 32'(s), 32'h05);
    hostRd(5'd3, s);
    check("R4 got data", 32'(s), 32'hAAAA);
    hostRd(5'd4, s);
    check("R5 expected kept from first mismatch", 32'(s), 32'hAAAB);
    check("R5 accesses before stall", 32'(txN), 32'd3);
    check("R5 no later write", 32'(mem[6]), 32'h0000);
    check("R5 mReq low", 32'(mReq), 32'd0);
  endtask

  task automatic tRestart();
    logic [25:0] s;
    hostWr(5'd17, ent(2'd2, 8'h05, 16'hAAAA));
    hostWr(5'd18, ent(2'd0, 8'h00, 16'h0));
    runWait("R10");
    hostRd(5'd1, s);
    check("R10 restart clears fail", 32'(s), 32'd2);
    hostRd(5'd2, s);
    check("R10 fail addr cleared", 32'(s), 32'd0);
    check("R10 from slot 0", 32'(txAddr[0]), 32'h05);
  endtask

  task automatic tLoop(input int cnt, input string tag);
    logic [25:0] s;
    int expN;
    expN = 1 + 2 * (cnt + 1);
    setLoop(cnt, 1, 2);
    hostWr(5'd16, ent(2'd1, 8'h10, 16'h0001));
    hostWr(5'd17, ent(2'd1, 8'h11, 16'h0002));
    hostWr(5'd18, ent(2'd2, 8'h11, 16'h0002));
    hostWr(5'd19, ent(2'd0, 8'h00, 16'h0));
    runWait(tag);
    hostRd(5'd1, s);
    check({tag, " loop done"}, 32'(s), 32'd2);
    check({tag, " access count"}, 32'(txN), 32'(expN));
    check({tag, " no gap"}, 32'(txCyc[txN-1] - txCyc[0]), 32'(expN - 1));
    check({tag, " last access read"}, {txAddr[txN-1], 7'd0, txWe[txN-1]}, {8'h11, 8'h00});
  endtask

  task automatic tLock();
    logic [25:0] s;
    setLoop(3, 0, 15);
    hostWr(5'd16, ent(2'd1, 8'h20, 16'h0005));
    hostWr(5'd17, ent(2'd0, 8'h00, 16'h0));
    gntMode = 2;
    repeat (3) @(negedge clk);
    txN = 0;
    hostWr(5'd0, 26'd1);
    repeat (3) @(negedge clk);
    check("R2 request held without grant", {23'd0, mReq, mAddr}, {23'd0, 1'b1, 8'h20});
    hostWr(5'd16, ent(2'd1, 8'h21, 16'h0009));
    hostWr(5'd5, 26'd7);
    hostRd(5'd16, s);
    check("R9 slot locked", 32'(s), 32'(ent(2'd1, 8'h20, 16'h0005)));
    hostRd(5'd5, s);
    check("R9 loop count locked", 32'(s), 32'd3);
    hostRd(5'd1, s);
    check("R9 still busy", 32'(s), 32'd1);
    gntMode = 0;
    for (int k = 0; k < 200 && s[0]; k++) hostRd(5'd1, s);
    check("R9 finished", 32'(s), 32'd2);
    check("R9 original slot ran", 32'(mem[8'h20]), 32'h0005);
    check("R9 altered slot not run", 32'(mem[8'h21]), 32'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tPass();
    tThrottle();
    tFault();
    tRestart();
    tLoop(2, "R7");
    tLoop(0, "R8");
    tLock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule